// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip. A sixteen-state controller is clocked by the test clock and steered by the mode-select input. Under that controller a 5-bit instruction register picks one of three data registers to sit between the serial input and the serial output. The three are a one-bit bypass stage, a 32-bit identification register, and a boundary chain of 261 cells. The chain has one cell per pin-side signal, including the tri-state controls.

The instruction register and the boundary chain each have two ranks. The shift rank moves serial data. The parallel rank holds the last committed value, and that value does not change while new bits are shifting in. Capture acts on the clock edge that leaves a Capture state. Shifting acts on each edge taken in a Shift state. Commit acts on the edge that leaves an Update state. The serial output changes on the falling edge of the test clock, and its enable is raised only while the controller is shifting.

The host drives the port as a plain state machine: it moves the controller with the mode-select input and streams bits least significant first. The pad logic reads `bsr_out` and uses `extest_en` to decide whether the boundary cells drive the pins.

Top module: `jtag_tap`

## Requirements
- R1: While `trst_n` is low at a rising `tck` edge, the controller goes to Test-Logic-Reset, `ir_out` becomes 5'b00001, `bsr_out` becomes all zeros, and at the falling edge `tdo` and `tdo_oe` become 0. Otherwise the controller follows the standard sixteen-state graph, one transition per rising edge.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state.
- R3: The edge that leaves Capture-IR loads 5'b00001 into the instruction shift rank. Each Shift-IR edge moves `tdi` into bit 4 and moves the rank one place toward bit 0, and bit 0 is the bit presented on `tdo`.
- R4: `ir_out` changes only on the edge that leaves Update-IR, where it takes the shift rank, or on an edge taken in Test-Logic-Reset. It holds its value throughout Shift-IR.
- R5: Every edge taken in Test-Logic-Reset sets `ir_out` to the identification code 5'b00001.
- R6: Instruction decode: 5'b00001 selects the identification register; 5'b00000 (drive pins) and 5'b00010 (sample/preload) select the boundary chain; 5'b11111 and every other code select the bypass stage.
- R7: The bypass stage captures 0 and adds one cycle of delay between `tdi` and `tdo`.
- R8: The identification register captures the parameter `ID_VALUE` (default 32'h4B7D2C19, bit 0 set to 1) and shifts it out least significant bit first.
- R9: With the boundary chain selected, leaving Capture-DR loads `bsr_pin_in` into the chain, and Shift-DR moves `tdi` in at cell 260 and out from cell 0. `bsr_out` takes the chain only on the edge that leaves Update-DR.
- R10: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is 1 exactly when the controller is in Shift-IR or Shift-DR, and `tdo` holds its value outside those states.
- R11: `extest_en` is 1 exactly while `ir_out` holds the drive-pins code 5'b00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low reset, sampled on the test clock edges |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in |
| bsr_pin_in | input | BSR_LEN (261) | Values seen at the pin side, captured into the boundary chain |
| tdo | output | 1 | Serial data out, changed on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| ir_out | output | 5 | Committed instruction |
| extest_en | output | 1 | Boundary cells drive the pins |
| bsr_out | output | BSR_LEN (261) | Committed boundary cell values |

## Verification
Each register is scanned with its own pattern. The instruction capture must come out as 1,0,0,0,0, and the identification read must produce the 32-bit constant; either result shows whether capture happened on the correct edge. A bypass scan and a scan under an undefined code both check for a leading 0 followed by the input delayed by one bit, which separates the bypass path from the identification path. A 261-bit scan under sample/preload puts one pattern on the pins and shifts in a different one. The bits shifted out must match the pins, and the committed cells must match the shifted-in pattern only after Update-DR. A run of five `tms`-high edges starting from Shift-DR, after a non-default instruction, shows whether the forced reset also restores the instruction.

// File: rtl/jtag_tap_pkg.sv
// Shared types for the test access port: controller states, instruction
// codes and the data-register selector. Assumes a 5-bit instruction.
package jtag_tap_pkg;

    localparam int IR_W = 5;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PAU_DR  = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PAU_IR  = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYP = 2'd0,
        DR_ID  = 2'd1,
        DR_BSC = 2'd2
    } dr_sel_e;

    localparam logic [IR_W-1:0] INS_EXTEST = 5'b00000;
    localparam logic [IR_W-1:0] INS_IDCODE = 5'b00001;
    localparam logic [IR_W-1:0] INS_SAMPLE = 5'b00010;
    localparam logic [IR_W-1:0] INS_BYPASS = 5'b11111;

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state test controller. Moves one step per rising tck edge,
// steered by tms. Assumes trst_n is sampled synchronously on tck.
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next-state graph of the controller.
    always_comb begin
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

endmodule

// File: rtl/tap_ir.sv
// Instruction register: a shift rank loaded with the identification code
// on leaving Capture-IR, and a parallel rank committed on leaving Update-IR
// or forced to the identification code in Test-Logic-Reset.
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so
);

    logic [IR_W-1:0] ir_sh;

    // Shift rank: capture the fixed code, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                ir_sh <= '0;
        else if (state == ST_CAP_IR) ir_sh <= INS_IDCODE;
        else if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Parallel rank: commit on update, restore in reset.
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_q <= INS_IDCODE;
        else if (state == ST_RESET)  ir_q <= INS_IDCODE;
        else if (state == ST_UPD_IR) ir_q <= ir_sh;
    end

    assign ir_so = ir_sh[0];

endmodule

// File: rtl/tap_dr.sv
// Data registers: the one-bit bypass stage, the identification register and
// the boundary chain with its update rank. Only the selected register
// captures or shifts. Assumes ID_VALUE has bit 0 set.
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN  = 261,
    parameter logic [31:0] ID_VALUE = 32'h4B7D2C19
) (
    input  logic               tck,
    input  logic               trst_n,
    input  tap_state_e         state,
    input  dr_sel_e            sel,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic [BSR_LEN-1:0] bsr_q,
    output logic               dr_so
);

    localparam int ID_W = 32;

    logic               byp;
    logic [ID_W-1:0]    id_sh;
    logic [BSR_LEN-1:0] bsr_sh;

    // Bypass stage: capture 0, otherwise a single delay.
    always_ff @(posedge tck) begin
        if (!trst_n) byp <= 1'b0;
        else if (sel == DR_BYP && state == ST_CAP_DR) byp <= 1'b0;
        else if (sel == DR_BYP && state == ST_SH_DR)  byp <= tdi;
    end

    // Identification register: capture the constant, then shift.
    always_ff @(posedge tck) begin
        if (!trst_n) id_sh <= '0;
        else if (sel == DR_ID && state == ST_CAP_DR) id_sh <= ID_VALUE;
        else if (sel == DR_ID && state == ST_SH_DR)  id_sh <= {tdi, id_sh[ID_W-1:1]};
    end

    // Boundary shift rank: capture the pin side, then shift.
    always_ff @(posedge tck) begin
        if (!trst_n) bsr_sh <= '0;
        else if (sel == DR_BSC && state == ST_CAP_DR) bsr_sh <= pin_in;
        else if (sel == DR_BSC && state == ST_SH_DR)  bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
    end

    // Boundary update rank: commit on leaving Update-DR.
    always_ff @(posedge tck) begin
        if (!trst_n) bsr_q <= '0;
        else if (sel == DR_BSC && state == ST_UPD_DR) bsr_q <= bsr_sh;
    end

    // Serial output of the selected register.
    always_comb begin
        unique case (sel)
            DR_ID:   dr_so = id_sh[0];
            DR_BSC:  dr_so = bsr_sh[0];
            default: dr_so = byp;
        endcase
    end

endmodule

// File: rtl/jtag_tap.sv
// Top of the test access port. Decodes the committed instruction into a
// data-register select, and retimes the serial output and its enable onto
// the falling tck edge. Assumes all inputs are synchronous to tck.
module jtag_tap
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN  = 261,
    parameter logic [31:0] ID_VALUE = 32'h4B7D2C19
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] bsr_pin_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [IR_W-1:0]    ir_out,
    output logic               extest_en,
    output logic [BSR_LEN-1:0] bsr_out
);

    tap_state_e cur_state;
    dr_sel_e    dr_sel;
    logic       ir_so;
    logic       dr_so;
    logic       in_shift;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (cur_state)
    );

    tap_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (cur_state),
        .tdi    (tdi),
        .ir_q   (ir_out),
        .ir_so  (ir_so)
    );

    tap_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dr (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (cur_state),
        .sel    (dr_sel),
        .tdi    (tdi),
        .pin_in (bsr_pin_in),
        .bsr_q  (bsr_out),
        .dr_so  (dr_so)
    );

    // Instruction decode into the data-register select.
    always_comb begin
        unique case (ir_out)
            INS_IDCODE:             dr_sel = DR_ID;
            INS_EXTEST, INS_SAMPLE: dr_sel = DR_BSC;
            default:                dr_sel = DR_BYP;
        endcase
    end

    assign extest_en = (ir_out == INS_EXTEST);
    assign in_shift  = (cur_state == ST_SH_IR) || (cur_state == ST_SH_DR);

    // Serial output stage on the falling edge; holds outside shifting.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= in_shift;
            if (in_shift) tdo <= (cur_state == ST_SH_IR) ? ir_so : dr_so;
        end
    end

endmodule

// File: rtl/jtag_tap_chk.sv
// Property checker for the test access port, attached by bind. Watches the
// controller state and the ports; holds a small counter of tms-high edges.
module jtag_tap_chk
    import jtag_tap_pkg::*;
#(
    parameter int BSR_LEN = 261
) (
    input logic               tck,
    input logic               trst_n,
    input logic               tms,
    input logic               tdo_oe,
    input logic [IR_W-1:0]    ir_out,
    input logic [BSR_LEN-1:0] bsr_out,
    input tap_state_e         cur_state
);

    logic [2:0] tms_run;

    // Count consecutive tms-high edges, saturating at five.
    always_ff @(posedge tck) begin
        if (!trst_n)             tms_run <= 3'd0;
        else if (!tms)           tms_run <= 3'd0;
        else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
    end

    // R2: five high edges in a row leave the controller in reset.
    a_r2_five_high_reset: assert property (@(posedge tck) disable iff (!trst_n)
        tms_run == 3'd5 |-> cur_state == ST_RESET);

    // R5: a cycle in reset is followed by the identification instruction.
    a_r5_reset_restores_id: assert property (@(posedge tck) disable iff (!trst_n)
        cur_state == ST_RESET |=> ir_out == INS_IDCODE);

    // R4: the instruction changes only after Update-IR or reset.
    a_r4_ir_holds: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(ir_out) |-> ($past(cur_state) == ST_UPD_IR || $past(cur_state) == ST_RESET));

    // R9: committed boundary cells change only after Update-DR.
    a_r9_bsr_commit_only: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(bsr_out) |-> $past(cur_state) == ST_UPD_DR);

    // R10: output enable, set at the falling edge, matches the shift states.
    a_r10_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == (cur_state == ST_SH_IR || cur_state == ST_SH_DR));

    // R1: capture of the instruction always moves on to shift or exit.
    a_r1_capture_ir_next: assert property (@(posedge tck) disable iff (!trst_n)
        cur_state == ST_CAP_IR |=> (cur_state == ST_SH_IR || cur_state == ST_EX1_IR));

endmodule

bind jtag_tap jtag_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .tdo_oe    (tdo_oe),
    .ir_out    (ir_out),
    .bsr_out   (bsr_out),
    .cur_state (cur_state)
);

// File: tb/jtag_tap_test.sv
// Bench for the test access port: a behavioural model with queues is
// stepped alongside the design and compared at every rising and falling
// edge, plus scan-level checks computed from the requirements.
module jtag_tap_test;

    localparam int          BL   = 261;
    localparam logic [31:0] IDV  = 32'h4B7D2C19;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BL-1:0] pins;
    logic          tdo, tdo_oe, extest_en;
    logic [4:0]    ir_out;
    logic [BL-1:0] bsr_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 tck = ~tck;

    jtag_tap #(.BSR_LEN(BL), .ID_VALUE(IDV)) uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .bsr_pin_in(pins), .tdo(tdo), .tdo_oe(tdo_oe),
        .ir_out(ir_out), .extest_en(extest_en), .bsr_out(bsr_out)
    );

    // ---------------- reference model ----------------
    int          ms;
    logic [4:0]  m_ir;
    logic [BL-1:0] m_bs;
    logic        m_tdo, m_oe;
    bit irq[$];
    bit bpq[$];
    bit idq[$];
    bit bsq[$];

    function automatic int nxt(int s, bit t);
        case (s)
            0: return t ? 0 : 1;     1: return t ? 2 : 1;
            2: return t ? 9 : 3;     3: return t ? 5 : 4;
            4: return t ? 5 : 4;     5: return t ? 8 : 6;
            6: return t ? 7 : 6;     7: return t ? 8 : 4;
            8: return t ? 2 : 1;     9: return t ? 0 : 10;
            10: return t ? 12 : 11;  11: return t ? 12 : 11;
            12: return t ? 15 : 13;  13: return t ? 14 : 13;
            14: return t ? 15 : 11;  default: return t ? 2 : 1;
        endcase
    endfunction

    // 0 bypass, 1 identification, 2 boundary
    function automatic int pick(logic [4:0] c);
        if (c == 5'b00001) return 1;
        if (c == 5'b00000 || c == 5'b00010) return 2;
        return 0;
    endfunction

    function automatic void fillq(ref bit q[$], input logic [BL-1:0] v, input int n);
        q.delete();
        for (int i = 0; i < n; i++) q.push_back(v[i]);
    endfunction

    function automatic void shq(ref bit q[$], input bit b);
        void'(q.pop_front());
        q.push_back(b);
    endfunction

    task automatic model_pos();
        if (!trst_n) begin
            ms = 0; m_ir = 5'b00001; m_bs = '0;
            fillq(irq, '0, 5); fillq(bpq, '0, 1);
            fillq(idq, '0, 32); fillq(bsq, '0, BL);
        end else begin
            case (ms)
                0:  m_ir = 5'b00001;
                10: fillq(irq, BL'(5'b00001), 5);
                11: shq(irq, tdi);
                15: for (int i = 0; i < 5; i++) m_ir[i] = irq[i];
                3: case (pick(m_ir))
                       1: fillq(idq, BL'(IDV), 32);
                       2: fillq(bsq, pins, BL);
                       default: fillq(bpq, '0, 1);
                   endcase
                4: case (pick(m_ir))
                       1: shq(idq, tdi);
                       2: shq(bsq, tdi);
                       default: shq(bpq, tdi);
                   endcase
                8: if (pick(m_ir) == 2) for (int i = 0; i < BL; i++) m_bs[i] = bsq[i];
                default: ;
            endcase
            ms = nxt(ms, tms);
        end
    endtask

    task automatic model_neg();
        if (!trst_n) begin
            m_tdo = 0; m_oe = 0;
        end else begin
            m_oe = (ms == 11 || ms == 4);
            if (ms == 11) m_tdo = irq[0];
            else if (ms == 4) begin
                case (pick(m_ir))
                    1: m_tdo = idq[0];
                    2: m_tdo = bsq[0];
                    default: m_tdo = bpq[0];
                endcase
            end
        end
    endtask

    task automatic chk(bit ok, string req, logic [BL-1:0] act, logic [BL-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One tck cycle: drive, rising edge + model, falling edge + model.
    task automatic step(bit t, bit d);
        tms = t; tdi = d;
        @(posedge tck); #1;
        model_pos();
        chk(ir_out === m_ir, "R4 ir_out per clock", BL'(ir_out), BL'(m_ir));
        chk(bsr_out === m_bs, "R9 bsr_out per clock", bsr_out, m_bs);
        chk(extest_en === (m_ir == 5'b00000), "R11 extest_en per clock",
            BL'(extest_en), BL'(m_ir == 5'b00000));
        @(negedge tck); #1;
        model_neg();
        chk(tdo_oe === m_oe, "R10 tdo_oe per clock", BL'(tdo_oe), BL'(m_oe));
        chk(tdo === m_tdo, "R10 tdo per clock", BL'(tdo), BL'(m_tdo));
    endtask

    // Scan n bits from Run-Test-Idle and back; returns bits seen on tdo.
    task automatic scan(bit is_ir, int n, logic [BL-1:0] din, output logic [BL-1:0] dout);
        dout = '0;
        step(1, 0);
        if (is_ir) step(1, 0);
        step(0, 0);
        step(0, 0);
        dout[0] = tdo;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            if (i < n - 1) dout[i + 1] = tdo;
        end
        step(1, 0);
        step(0, 0);
    endtask

    logic [BL-1:0] pat_p, pat_q, got;

    initial begin
        for (int i = 0; i < BL; i++) begin
            pat_p[i] = ((i * 7) % 3) == 0;
            pat_q[i] = ((i * 5) % 4) < 2;
        end
        pins = pat_p;
        model_pos(); model_neg();
        for (int i = 0; i < 4; i++) step(1, 0);
        trst_n = 1'b1;
        // R1: reset state at the ports
        chk(ir_out == 5'b00001, "R1 reset instruction", BL'(ir_out), BL'(5'b00001));
        chk(tdo_oe == 1'b0, "R1 reset tdo_oe", BL'(tdo_oe), '0);
        chk(bsr_out == '0, "R1 reset boundary", bsr_out, '0);
        step(0, 0);

        // R3: instruction capture reads out 1,0,0,0,0; load bypass code
        scan(1, 5, BL'(5'b11111), got);
        chk(got[4:0] == 5'b00001, "R3 capture-IR pattern", BL'(got[4:0]), BL'(5'b00001));
        chk(ir_out == 5'b11111, "R4 committed bypass code", BL'(ir_out), BL'(5'b11111));

        // R7: bypass gives a leading 0 then tdi delayed by one
        scan(0, 8, BL'(8'b1011_0110), got);
        chk(got[7:0] == {7'b011_0110, 1'b0}, "R7 bypass delay", BL'(got[7:0]),
            BL'({7'b011_0110, 1'b0}));

        // R6: undefined code 10101 acts as bypass
        scan(1, 5, BL'(5'b10101), got);
        chk(ir_out == 5'b10101, "R6 undefined code committed", BL'(ir_out), BL'(5'b10101));
        scan(0, 6, BL'(6'b11_0101), got);
        chk(got[5:0] == {5'b1_0101, 1'b0}, "R6 undefined code bypasses", BL'(got[5:0]),
            BL'({5'b1_0101, 1'b0}));

        // R8: identification register readout
        scan(1, 5, BL'(5'b00001), got);
        scan(0, 32, '0, got);
        chk(got[31:0] == IDV, "R8 identification value", BL'(got[31:0]), BL'(IDV));

        // R9: sample/preload captures the pins and commits the shifted pattern
        scan(1, 5, BL'(5'b00010), got);
        chk(extest_en == 1'b0, "R11 sample does not drive", BL'(extest_en), '0);
        scan(0, BL, pat_q, got);
        chk(got == pat_p, "R9 pins captured", got, pat_p);
        chk(bsr_out == pat_q, "R9 pattern committed", bsr_out, pat_q);

        // R11: drive-pins code raises extest_en, cells unchanged
        scan(1, 5, BL'(5'b00000), got);
        chk(extest_en == 1'b1, "R11 extest enable", BL'(extest_en), BL'(1'b1));
        chk(bsr_out == pat_q, "R9 cells held across IR scan", bsr_out, pat_q);

        // R2/R5: from Shift-DR, five tms-high edges restore the instruction
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(1, 0);
        chk(ir_out == 5'b00001, "R2 forced reset restores R5 instruction",
            BL'(ir_out), BL'(5'b00001));
        chk(extest_en == 1'b0, "R5 reset stops pin drive", BL'(extest_en), '0);
        step(0, 0);
        chk(tdo_oe == 1'b0, "R10 idle has no enable", BL'(tdo_oe), '0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule